// File: doc/BRIEF.md
# Decrementer Timer with Selectable Underflow Behaviour

The block holds two down-counters of parameterised width, 32 bits by default. One is the main decrementer. The other is a supervisor-level decrementer that carries a power-managed suppression input. Each counter steps down by one on every cycle in which the shared time-base tick enable is high. Software can overwrite either counter at any time through a write strobe and data bus, and it reads the live value from the count output.

Each counter drives an interrupt request. The request is raised when the counter passes below zero, when software writes a value that is about to expire, or when a write turns the top bit on. It is cleared when software pulses the lower input. In the edge-only configuration it is also cleared when the core signals delivery.

Two static parameters select the underflow behaviour. The edge mode reacts to the top bit rising. The level mode keeps the request up for as long as the top bit is set. A runtime input switches both counters to saturating behaviour, in which they stop at zero instead of wrapping.

Top module: `dectmr_top`

## Requirements
- R1: After a cycle with `rst` high, both counts read all-ones and the pending state is clear. In the edge-only configuration both interrupts are then low. In level configuration they are high, because bit W-1 is set.
- R2: A count decreases by exactly one in each cycle where `tick_en` is high and no load or refill occurs. In a cycle where `tick_en` is low, the count holds its value.
- R3: A write strobe loads its data into the count on the next edge. It takes priority over a tick in the same cycle.
- R4: `rate_change` refills both counts with all-ones. It takes priority over a write and a tick in the same cycle, and it leaves the pending state unchanged.
- R5: Without saturation, a tick at count zero wraps the count to all-ones and sets the pending interrupt.
- R6: With `sat_mode` high, a tick at count one reaches zero and sets the pending interrupt. A tick at count zero keeps the count at zero and raises nothing.
- R7: When edge mode is enabled, a write whose bit W-1 is set, into a count whose bit W-1 is clear, sets the pending interrupt. If the count's bit W-1 was already set, the same write does not set it.
- R8: A written value of 0 or 1 sets the pending interrupt at once, without waiting for a tick.
- R9: A lower pulse clears the pending interrupt. If a raise occurs in the same cycle, the raise wins.
- R10: In level configuration, the interrupt output is high while bit W-1 of the count is 1, or while an interrupt is pending. A write whose bit W-1 is clear clears the pending state, and this overrides the small-value raise of R8.
- R11: A deliver pulse clears the pending interrupt only in the edge-only configuration. In level configuration it has no effect.
- R12: On the supervisor counter, an expiry from a tick while `h_pm` is high is discarded. It is not raised after `h_pm` falls. While `h_pm` is high, the level term of R10 is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base tick, one decrement per high cycle |
| rate_change | input | 1 | Tick rate reconfigured; refill both counts with all-ones |
| sat_mode | input | 1 | Saturate at zero instead of wrapping |
| m_wr_en | input | 1 | Main counter write strobe |
| m_wr_data | input | W | Main counter write value |
| m_lower | input | 1 | Main interrupt acknowledge |
| m_deliver | input | 1 | Main interrupt taken by the core |
| m_count | output | W | Main counter value |
| m_irq | output | 1 | Main interrupt request |
| h_pm | input | 1 | Power-managed state; suppresses supervisor expiry |
| h_wr_en | input | 1 | Supervisor counter write strobe |
| h_wr_data | input | W | Supervisor counter write value |
| h_lower | input | 1 | Supervisor interrupt acknowledge |
| h_deliver | input | 1 | Supervisor interrupt taken by the core |
| h_count | output | W | Supervisor counter value |
| h_irq | output | 1 | Supervisor interrupt request |

## Verification
A corrupted count shows on the count port one edge after the cycle that produced it. Because every later tick keeps that offset, the error also moves the expiry interrupt by the same number of ticks. A wrong pending bit shows on the interrupt output in the very next cycle, except in level configuration while bit W-1 is set, where the level term hides it until the count's top bit clears. Pending bits that are lost or stuck are therefore exposed by driving counts across zero and across the top-bit boundary, with lower and deliver pulses placed between those crossings.

// File: rtl/dectmr_pkg.sv
package dectmr_pkg;

    // Which value the counter takes on the next edge.
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_TICK = 2'd1,
        SRC_LOAD = 2'd2,
        SRC_FULL = 2'd3
    } src_e;

    // Per-cycle decisions made for one counter.
    typedef struct packed {
        src_e src;
        logic raise;      // set pending
        logic clr;        // acknowledge or delivery
        logic force_clr;  // level-mode write with top bit clear
        logic hide;       // mask level term (power-managed)
    } evt_t;

    // Refill beats a write, and a write beats a tick.
    function automatic src_e pick_src(input logic refill, input logic wr, input logic tick);
        if (refill)      return SRC_FULL;
        else if (wr)     return SRC_LOAD;
        else if (tick)   return SRC_TICK;
        else             return SRC_HOLD;
    endfunction

endpackage

// File: rtl/dectmr_evt.sv
module dectmr_evt
    import dectmr_pkg::*;
#(
    parameter int W          = 32,
    parameter bit LEVEL_MODE = 1'b0,
    parameter bit EDGE_MODE  = 1'b1,
    parameter bit HAS_PM     = 1'b0
) (
    input  logic [W-1:0] cnt,
    input  logic         refill,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         tick,
    input  logic         sat,
    input  logic         lower,
    input  logic         deliver,
    input  logic         pm,
    output evt_t         evt
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    logic supp, at_zero, at_one, expire, wr_raise;
    src_e src;

    assign src     = pick_src(refill, wr_en, tick);
    assign supp    = pm & HAS_PM;
    assign at_zero = (cnt == ZERO);
    assign at_one  = (cnt == ONE);

    // Expiry: wrap below zero, or arrival at zero when saturating.
    assign expire = (src == SRC_TICK) && ((!sat && at_zero) || (sat && at_one));

    assign wr_raise = (src == SRC_LOAD) &&
                      ((wr_data <= ONE) ||
                       (LEVEL_MODE && wr_data[W-1]) ||
                       (EDGE_MODE && wr_data[W-1] && !cnt[W-1]));

    always_comb begin
        evt.src       = src;
        evt.raise     = wr_raise | (expire & ~supp);
        evt.clr       = lower | (deliver & EDGE_MODE & ~LEVEL_MODE);
        evt.force_clr = (src == SRC_LOAD) & LEVEL_MODE & ~wr_data[W-1];
        evt.hide      = supp;
    end
endmodule

// File: rtl/dectmr_core.sv
module dectmr_core
    import dectmr_pkg::*;
#(
    parameter int W          = 32,
    parameter bit LEVEL_MODE = 1'b0,
    parameter bit EDGE_MODE  = 1'b1,
    parameter bit HAS_PM     = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         refill,
    input  logic         sat,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         lower,
    input  logic         deliver,
    input  logic         pm,
    output logic [W-1:0] count,
    output logic         irq
);
    localparam logic [W-1:0] ALL1 = '1;
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] cnt_q, cnt_d;
    logic         pend_q, pend_d;
    evt_t         evt;

    dectmr_evt #(
        .W(W), .LEVEL_MODE(LEVEL_MODE), .EDGE_MODE(EDGE_MODE), .HAS_PM(HAS_PM)
    ) u_evt (
        .cnt(cnt_q), .refill(refill), .wr_en(wr_en), .wr_data(wr_data),
        .tick(tick_en), .sat(sat), .lower(lower), .deliver(deliver),
        .pm(pm), .evt(evt)
    );

    always_comb begin
        unique case (evt.src)
            SRC_FULL: cnt_d = ALL1;
            SRC_LOAD: cnt_d = wr_data;
            SRC_TICK: cnt_d = (sat && cnt_q == ZERO) ? cnt_q : cnt_q - ONE;
            default:  cnt_d = cnt_q;
        endcase
    end

    always_comb begin
        if (evt.force_clr)  pend_d = 1'b0;
        else if (evt.raise) pend_d = 1'b1;
        else if (evt.clr)   pend_d = 1'b0;
        else                pend_d = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= ALL1;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    generate
        if (LEVEL_MODE) begin : g_level
            assign irq = pend_q | (cnt_q[W-1] & ~evt.hide);
        end else begin : g_edge
            assign irq = pend_q;
        end
    endgenerate

    assign count = cnt_q;
endmodule

// File: rtl/dectmr_top.sv
module dectmr_top #(
    parameter int W          = 32,
    parameter bit LEVEL_MODE = 1'b0,
    parameter bit EDGE_MODE  = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         rate_change,
    input  logic         sat_mode,
    input  logic         m_wr_en,
    input  logic [W-1:0] m_wr_data,
    input  logic         m_lower,
    input  logic         m_deliver,
    output logic [W-1:0] m_count,
    output logic         m_irq,
    input  logic         h_pm,
    input  logic         h_wr_en,
    input  logic [W-1:0] h_wr_data,
    input  logic         h_lower,
    input  logic         h_deliver,
    output logic [W-1:0] h_count,
    output logic         h_irq
);
    dectmr_core #(
        .W(W), .LEVEL_MODE(LEVEL_MODE), .EDGE_MODE(EDGE_MODE), .HAS_PM(1'b0)
    ) u_main (
        .clk(clk), .rst(rst), .tick_en(tick_en), .refill(rate_change),
        .sat(sat_mode), .wr_en(m_wr_en), .wr_data(m_wr_data),
        .lower(m_lower), .deliver(m_deliver), .pm(1'b0),
        .count(m_count), .irq(m_irq)
    );

    dectmr_core #(
        .W(W), .LEVEL_MODE(LEVEL_MODE), .EDGE_MODE(EDGE_MODE), .HAS_PM(1'b1)
    ) u_hyp (
        .clk(clk), .rst(rst), .tick_en(tick_en), .refill(rate_change),
        .sat(sat_mode), .wr_en(h_wr_en), .wr_data(h_wr_data),
        .lower(h_lower), .deliver(h_deliver), .pm(h_pm),
        .count(h_count), .irq(h_irq)
    );
endmodule

// File: rtl/dectmr_chk.sv
module dectmr_chk #(
    parameter int W          = 32,
    parameter bit LEVEL_MODE = 1'b0
) (
    input logic         clk,
    input logic         rst,
    input logic         tick_en,
    input logic         rate_change,
    input logic         sat_mode,
    input logic         m_wr_en,
    input logic [W-1:0] m_wr_data,
    input logic [W-1:0] m_count,
    input logic         m_irq,
    input logic         h_pm,
    input logic         h_wr_en,
    input logic [W-1:0] h_count,
    input logic         h_irq
);
    localparam logic [W-1:0] ALL1 = '1;
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    always @(posedge clk) begin
        assert_reset_full_R1: assert property (
            rst |=> (m_count == ALL1 && h_count == ALL1));
    end

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        (!rate_change && !m_wr_en && !tick_en) |=> $stable(m_count));

    assert_tick_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!rate_change && !m_wr_en && tick_en && m_count != ZERO)
        |=> (m_count == $past(m_count) - ONE));

    assert_write_load_R3: assert property (@(posedge clk) disable iff (rst)
        (!rate_change && m_wr_en) |=> (m_count == $past(m_wr_data)));

    assert_refill_R4: assert property (@(posedge clk) disable iff (rst)
        rate_change |=> (m_count == ALL1 && h_count == ALL1));

    assert_wrap_raise_R5: assert property (@(posedge clk) disable iff (rst)
        (!rate_change && !m_wr_en && tick_en && !sat_mode && m_count == ZERO)
        |=> (m_irq && m_count == ALL1));

    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!rate_change && !m_wr_en && tick_en && sat_mode && m_count == ZERO)
        |=> (m_count == ZERO));

    assert_pm_discard_R12: assert property (@(posedge clk) disable iff (rst)
        (!LEVEL_MODE && h_pm && !h_irq && !h_wr_en) |=> !h_irq);
endmodule

bind dectmr_top dectmr_chk #(.W(W), .LEVEL_MODE(LEVEL_MODE)) u_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rate_change(rate_change),
    .sat_mode(sat_mode), .m_wr_en(m_wr_en), .m_wr_data(m_wr_data),
    .m_count(m_count), .m_irq(m_irq), .h_pm(h_pm), .h_wr_en(h_wr_en),
    .h_count(h_count), .h_irq(h_irq)
);

// File: tb/tb_dectmr_top.sv
module tb_dectmr_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, tick_en = 0, rate_change = 0, sat_mode = 0;
    logic m_wr_en = 0, m_lower = 0, m_deliver = 0;
    logic h_wr_en = 0, h_lower = 0, h_deliver = 0, h_pm = 0;
    logic [31:0] m_wr_data = '0, h_wr_data = '0;
    logic [31:0] e_mc, e_hc, l_mc, l_hc;
    logic e_mi, e_hi, l_mi, l_hi;

    dectmr_top dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rate_change(rate_change),
        .sat_mode(sat_mode), .m_wr_en(m_wr_en), .m_wr_data(m_wr_data),
        .m_lower(m_lower), .m_deliver(m_deliver), .m_count(e_mc), .m_irq(e_mi),
        .h_pm(h_pm), .h_wr_en(h_wr_en), .h_wr_data(h_wr_data),
        .h_lower(h_lower), .h_deliver(h_deliver), .h_count(e_hc), .h_irq(e_hi));

    dectmr_top #(.LEVEL_MODE(1'b1), .EDGE_MODE(1'b1)) dut_lvl (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rate_change(rate_change),
        .sat_mode(sat_mode), .m_wr_en(m_wr_en), .m_wr_data(m_wr_data),
        .m_lower(m_lower), .m_deliver(m_deliver), .m_count(l_mc), .m_irq(l_mi),
        .h_pm(h_pm), .h_wr_en(h_wr_en), .h_wr_data(h_wr_data),
        .h_lower(h_lower), .h_deliver(h_deliver), .h_count(l_hc), .h_irq(l_hi));

    int n_chk = 0, n_bad = 0;

    // Reference model, written from the requirements.
    typedef struct packed { logic [31:0] c; logic p; } st_t;
    st_t me_m, me_h, ml_m, ml_h;

    function automatic st_t mstep(st_t s, bit lvl, bit supp, bit pm, bit rs,
                                  bit rf, bit wr, logic [31:0] wd, bit tk,
                                  bit sat, bit low, bit dlv);
        st_t n = s;
        bit up = 0, kill = 0;
        if (rs) begin n.c = '1; n.p = 0; return n; end
        if (rf) n.c = '1;
        else if (wr) begin
            n.c = wd;
            if (wd < 2) up = 1;
            if (wd[31] && (lvl || !s.c[31])) up = 1;
            if (lvl && !wd[31]) kill = 1;
        end else if (tk) begin
            n.c = (sat && s.c == 0) ? s.c : s.c - 1;
            if (((!sat && s.c == 0) || (sat && s.c == 1)) && !(supp && pm)) up = 1;
        end
        if (kill) n.p = 0;
        else if (up) n.p = 1;
        else if (low || (dlv && !lvl)) n.p = 0;
        return n;
    endfunction

    function automatic logic mirq(st_t s, bit lvl, bit supp, bit pm);
        return s.p | (lvl & s.c[31] & !(supp && pm));
    endfunction

    always @(posedge clk) begin
        me_m = mstep(me_m, 0, 0, 0,    rst, rate_change, m_wr_en, m_wr_data, tick_en, sat_mode, m_lower, m_deliver);
        me_h = mstep(me_h, 0, 1, h_pm, rst, rate_change, h_wr_en, h_wr_data, tick_en, sat_mode, h_lower, h_deliver);
        ml_m = mstep(ml_m, 1, 0, 0,    rst, rate_change, m_wr_en, m_wr_data, tick_en, sat_mode, m_lower, m_deliver);
        ml_h = mstep(ml_h, 1, 1, h_pm, rst, rate_change, h_wr_en, h_wr_data, tick_en, sat_mode, h_lower, h_deliver);
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clr();
        tick_en = 0; rate_change = 0; m_wr_en = 0; h_wr_en = 0;
        m_lower = 0; h_lower = 0; m_deliver = 0; h_deliver = 0;
    endtask

    // Same write / pulses on both counters.
    task automatic wr(logic [31:0] v);
        m_wr_en = 1; h_wr_en = 1; m_wr_data = v; h_wr_data = v;
    endtask
    task automatic low();
        m_lower = 1; h_lower = 1;
    endtask
    task automatic dlv();
        m_deliver = 1; h_deliver = 1;
    endtask
    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) step();
        chk("R1 main count", e_mc, 32'hFFFF_FFFF);
        chk("R1 hyp count", e_hc, 32'hFFFF_FFFF);
        chk("R1 edge irq", {31'b0, e_mi}, 0);
        chk("R1 level irq", {31'b0, l_mi}, 1);
        rst = 0;

        step();                          chk("R2 hold", e_mc, 32'hFFFF_FFFF);
        tick_en = 1; step(); clr();      chk("R2 tick", e_mc, 32'hFFFF_FFFE);
        wr(5); tick_en = 1; step(); clr();
        chk("R3 write beats tick", e_mc, 5);
        chk("R10 level top bit clear", {31'b0, l_mi}, 0);
        wr(1); step(); clr();
        chk("R8 small write raises", {31'b0, e_mi}, 1);
        chk("R10 level clear overrides small", {31'b0, l_mi}, 0);
        low(); step(); clr();            chk("R9 lower", {31'b0, e_mi}, 0);
        tick_en = 1; step(); clr();      chk("R2 to zero", e_mc, 0);
        tick_en = 1; low(); step(); clr();
        chk("R5 wrap count", e_mc, 32'hFFFF_FFFF);
        chk("R5 R9 wrap raise beats lower", {31'b0, e_mi}, 1);
        dlv(); step(); clr();
        chk("R11 deliver clears edge", {31'b0, e_mi}, 0);
        wr(32'h10); step(); clr();
        wr(32'h8000_0000); step(); clr();
        chk("R7 top bit rise", {31'b0, e_mi}, 1);
        tick_en = 1; step(); clr();
        chk("R10 level pending persists", {31'b0, l_mi}, 1);
        dlv(); step(); clr();
        chk("R11 deliver edge", {31'b0, e_mi}, 0);
        chk("R11 deliver ignored level", {31'b0, l_mi}, 1);
        low(); step(); clr();            chk("R9 lower level", {31'b0, l_mi}, 0);
        wr(32'h8000_0001); step(); clr();
        low(); step(); clr();
        wr(32'h8000_0005); step(); clr();
        chk("R7 top bit already set", {31'b0, e_mi}, 0);

        sat_mode = 1;
        wr(2); step(); clr();
        tick_en = 1; step(); clr();      chk("R6 no raise at one", {31'b0, e_mi}, 0);
        tick_en = 1; step(); clr();      chk("R6 raise on reaching zero", {31'b0, e_mi}, 1);
        low(); step(); clr();
        tick_en = 1; step(); clr();
        chk("R6 hold at zero", e_mc, 0);
        chk("R6 no raise at zero", {31'b0, e_mi}, 0);
        sat_mode = 0;

        wr(1); step(); clr();
        rate_change = 1; wr(7); tick_en = 1; step(); clr();
        chk("R4 refill", e_mc, 32'hFFFF_FFFF);
        chk("R4 refill hyp", e_hc, 32'hFFFF_FFFF);
        chk("R4 pending kept", {31'b0, e_mi}, 1);
        low(); step(); clr();

        h_pm = 1;
        wr(2); step(); clr();
        repeat (3) begin tick_en = 1; step(); clr(); end
        chk("R12 hyp wrapped", e_hc, 32'hFFFF_FFFF);
        chk("R12 discarded", {31'b0, e_hi}, 0);
        chk("R12 main unaffected", {31'b0, e_mi}, 1);
        chk("R12 level masked", {31'b0, l_hi}, 0);
        h_pm = 0; step();
        chk("R12 not held", {31'b0, e_hi}, 0);
        chk("R12 level unmasked", {31'b0, l_hi}, 1);

        for (int i = 0; i < 4000; i++) begin
            tick_en     = ($urandom_range(0, 3) != 0);
            rate_change = ($urandom_range(0, 40) == 0);
            sat_mode    = (i % 700) > 450;
            h_pm        = ($urandom_range(0, 2) == 0);
            m_wr_en     = ($urandom_range(0, 7) == 0);
            h_wr_en     = ($urandom_range(0, 7) == 0);
            m_lower     = ($urandom_range(0, 9) == 0);
            h_lower     = ($urandom_range(0, 9) == 0);
            m_deliver   = ($urandom_range(0, 9) == 0);
            h_deliver   = ($urandom_range(0, 9) == 0);
            for (int k = 0; k < 2; k++) begin
                logic [31:0] v;
                case ($urandom_range(0, 6))
                    0: v = 0;  1: v = 1;  2: v = 2;
                    3: v = $urandom_range(3, 12);
                    4: v = 32'h8000_0000 | $urandom_range(0, 3);
                    5: v = 32'h7FFF_FFFF;
                    default: v = $urandom;
                endcase
                if (k == 0) m_wr_data = v; else h_wr_data = v;
            end
            step();
            chk("MIX edge main count", e_mc, me_m.c);
            chk("MIX edge hyp count", e_hc, me_h.c);
            chk("MIX edge main irq", {31'b0, e_mi}, {31'b0, mirq(me_m, 0, 0, 0)});
            chk("MIX edge hyp irq", {31'b0, e_hi}, {31'b0, mirq(me_h, 0, 1, h_pm)});
            chk("MIX level main count", l_mc, ml_m.c);
            chk("MIX level hyp count", l_hc, ml_h.c);
            chk("MIX level main irq", {31'b0, l_mi}, {31'b0, mirq(ml_m, 1, 0, 0)});
            chk("MIX level hyp irq", {31'b0, l_hi}, {31'b0, mirq(ml_h, 1, 1, h_pm)});
        end
        clr();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule